// File: doc/BRIEF.md
# Selectable-Polynomial Frame Check Unit

This block is a 16-bit cyclic check accumulator that a synchronous serial transmitter and receiver share. It takes in one data bit on each clock cycle in which the bit strobe is high. It supports two protocol families.

- **Bit-oriented framing** uses the CCITT polynomial, a register preset to all ones, and an inverted remainder.
- **Byte-control blocks** use either CRC-16 or CCITT, selected by an input, with a register preset to zeros and the true remainder sent as-is.

A third mode turns error control off.

On transmit, the owner clears the unit at the start of the message and feeds it every data bit. It then raises `shiftOut` for sixteen cycles to draw the check field serially. On receive, the owner feeds the data bits and then the received check bits. It pulses `endFrame`, and the unit registers a pass/fail verdict by comparing the register with the residue that a correct message leaves.

Top module: `fcs_unit`

## Requirements
- R1: In bit-oriented mode (`modeSel`=01) the register divides by x^16+x^12+x^5+1 (0x1021), and `clearFrame` presets it to 0xFFFF.
- R2: In bit-oriented mode, each cycle with `shiftOut` high presents one check bit on `checkOut` with `checkValid` high. Over 16 cycles these bits form the ones' complement of the remainder, most significant bit first.
- R3: In byte-control mode (`modeSel`=10), `clearFrame` presets the register to 0x0000. `polySel`=0 selects x^16+x^15+x^2+1 (0x8005) and `polySel`=1 selects 0x1021.
- R4: In byte-control mode, the 16 check bits drawn by `shiftOut` are the true remainder, most significant bit first.
- R5: With `modeSel` at 00 or 11 (no error control), data bits do not change the register, `checkValid` stays low, and `endFrame` leaves `errFlag` low.
- R6: Each cycle with `bitValid` high folds `bitIn` into the register with feedback = register bit 15 XOR `bitIn`; cycles with `bitValid` low leave it unchanged. Data characters are fed least significant bit first.
- R7: In bit-oriented mode, an `endFrame` pulse sets `errFlag` in the following cycle exactly when the register differs from the residue 0x1D0F.
- R8: In byte-control mode, an `endFrame` pulse sets `errFlag` exactly when the register is non-zero. `errFlag` holds until the next `endFrame` or `clearFrame`, and `clearFrame` drops it to 0.
- R9: Synchronous reset loads the preset of the selected mode and clears `errFlag`.
- R10: When `clearFrame` is high, it takes priority over `bitValid`, `shiftOut` and `endFrame` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous reset, active high |
| modeSel | input | 2 | 00 none, 01 bit-oriented, 10 byte-control, 11 none |
| polySel | input | 1 | Byte-control polynomial: 0 CRC-16, 1 CCITT |
| clearFrame | input | 1 | Start-of-message preset |
| bitValid | input | 1 | Strobe for `bitIn` |
| bitIn | input | 1 | Serial data bit |
| shiftOut | input | 1 | Request for one check bit |
| endFrame | input | 1 | Evaluate received message |
| checkOut | output | 1 | Serial check bit |
| checkValid | output | 1 | `checkOut` carries a check bit |
| errFlag | output | 1 | Receive check failed |

## Verification
`checkOut` and `checkValid` are combinational from the register and the current inputs. The bench therefore reads them a short delay after it drives `shiftOut` at the falling edge, before the rising edge that shifts the register.

The register changes at the rising edge that follows a `bitValid` or `clearFrame` cycle. `errFlag` appears one rising edge after `endFrame`, so the bench samples it at the next falling edge.

Expected check fields and verdicts come from a bitwise polynomial division that the bench performs itself. The bench sweeps every mode and polynomial over several message lengths, each as an intact message and as a corrupted one.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [1:0] {
    MODE_NONE  = 2'b00,
    MODE_BIT   = 2'b01,
    MODE_BYTE  = 2'b10,
    MODE_NONE2 = 2'b11
  } modeT;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic load;    // preset register, clear verdict
    logic accum;   // fold one data bit
    logic shift;   // emit one check bit
    logic eval;    // latch verdict
    logic invert;  // complement emitted bits
    logic active;  // error control on
  } strobeT;
endpackage

// File: rtl/fcs_ctrl.sv
module fcs_ctrl
  import fcs_pkg::*;
#(
  parameter int W = 16,
  parameter logic [W-1:0] POLY_CCITT = 16'h1021,
  parameter logic [W-1:0] POLY_CRC16 = 16'h8005,
  parameter logic [W-1:0] BIT_RESIDUE = 16'h1D0F
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   modeSel,
  input  logic         polySel,
  input  logic         clearFrame,
  input  logic         bitValid,
  input  logic         shiftOut,
  input  logic         endFrame,
  output strobeT       strb,
  output logic [W-1:0] polyVal,
  output logic [W-1:0] presetVal,
  output logic [W-1:0] residueVal
);
  logic isBit, isByte;

  always_comb begin
    isBit  = (modeT'(modeSel) == MODE_BIT);
    isByte = (modeT'(modeSel) == MODE_BYTE);
    strb.load   = clearFrame;
    strb.active = isBit | isByte;
    strb.accum  = strb.active & bitValid & ~clearFrame;
    strb.shift  = strb.active & shiftOut & ~clearFrame & ~bitValid;
    strb.eval   = endFrame & ~clearFrame;
    strb.invert = isBit;
    presetVal   = isBit ? {W{1'b1}} : {W{1'b0}};
    residueVal  = isBit ? BIT_RESIDUE : {W{1'b0}};
    polyVal     = (isBit | polySel) ? POLY_CCITT : POLY_CRC16;
  end

  // R10: clear wins over every other request
  p_clear_priority_r10: assert property (@(posedge clk) disable iff (rst)
    clearFrame |-> !strb.accum && !strb.shift && !strb.eval);
  // R5: no error control -> nothing emitted or folded
  p_none_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (modeSel == 2'b00 || modeSel == 2'b11) |-> !strb.shift && !strb.accum);
endmodule

// File: rtl/fcs_datapath.sv
module fcs_datapath
  import fcs_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  strobeT       strb,
  input  logic [W-1:0] polyVal,
  input  logic [W-1:0] presetVal,
  input  logic [W-1:0] residueVal,
  input  logic         bitIn,
  output logic         serialOut,
  output logic         errOut,
  output logic [W-1:0] crcState
);
  logic [W-1:0] crcReg, crcNext;
  logic         errReg, feedback;

  always_comb begin
    feedback = crcReg[W-1] ^ bitIn;
    crcNext  = {crcReg[W-2:0], 1'b0} ^ (feedback ? polyVal : {W{1'b0}});
  end

  always_ff @(posedge clk) begin
    if (rst || strb.load) begin
      crcReg <= presetVal;
      errReg <= 1'b0;
    end else begin
      if (strb.accum)      crcReg <= crcNext;
      else if (strb.shift) crcReg <= {crcReg[W-2:0], 1'b0};
      if (strb.eval)       errReg <= strb.active && (crcReg != residueVal);
    end
  end

  assign serialOut = crcReg[W-1] ^ strb.invert;
  assign errOut    = errReg;
  assign crcState  = crcReg;

  // R8: verdict changes only on evaluate or clear
  p_err_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !strb.load && !strb.eval |=> $stable(errReg));
  // R6: idle cycles keep the register
  p_idle_stable_r6: assert property (@(posedge clk) disable iff (rst)
    !strb.load && !strb.accum && !strb.shift |=> $stable(crcReg));
endmodule

// File: rtl/fcs_unit.sv
module fcs_unit
  import fcs_pkg::*;
#(
  parameter int W = 16,
  parameter logic [W-1:0] POLY_CCITT = 16'h1021,
  parameter logic [W-1:0] POLY_CRC16 = 16'h8005,
  parameter logic [W-1:0] BIT_RESIDUE = 16'h1D0F
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] modeSel,
  input  logic       polySel,
  input  logic       clearFrame,
  input  logic       bitValid,
  input  logic       bitIn,
  input  logic       shiftOut,
  input  logic       endFrame,
  output logic       checkOut,
  output logic       checkValid,
  output logic       errFlag
);
  strobeT       strb;
  logic [W-1:0] polyVal, presetVal, residueVal, crcState;

  fcs_ctrl #(.W(W), .POLY_CCITT(POLY_CCITT), .POLY_CRC16(POLY_CRC16),
             .BIT_RESIDUE(BIT_RESIDUE)) u_ctrl (
    .clk(clk), .rst(rst), .modeSel(modeSel), .polySel(polySel),
    .clearFrame(clearFrame), .bitValid(bitValid), .shiftOut(shiftOut),
    .endFrame(endFrame), .strb(strb), .polyVal(polyVal),
    .presetVal(presetVal), .residueVal(residueVal)
  );

  fcs_datapath #(.W(W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .polyVal(polyVal),
    .presetVal(presetVal), .residueVal(residueVal), .bitIn(bitIn),
    .serialOut(checkOut), .errOut(errFlag), .crcState(crcState)
  );

  assign checkValid = strb.shift;

  // R1: bit-oriented clear presets all ones
  p_bit_preset_r1: assert property (@(posedge clk) disable iff (rst)
    clearFrame && modeSel == 2'b01 |=> crcState == {W{1'b1}});
  // R3: byte-control clear presets zeros
  p_byte_preset_r3: assert property (@(posedge clk) disable iff (rst)
    clearFrame && modeSel == 2'b10 |=> crcState == {W{1'b0}});
  // R8: clear drops the verdict
  p_err_clear_r8: assert property (@(posedge clk) disable iff (rst)
    clearFrame |=> !errFlag);
  // R5: no check bits without error control
  p_no_check_none_r5: assert property (@(posedge clk) disable iff (rst)
    (modeSel == 2'b00 || modeSel == 2'b11) |-> !checkValid);
endmodule

// File: tb/sim_fcs_unit.sv
module sim_fcs_unit;
  localparam int CLK_P = 10;

  logic clk = 0, rst = 1;
  logic [1:0] modeSel = 2'b01;
  logic polySel = 0, clearFrame = 0, bitValid = 0, bitIn = 0;
  logic shiftOut = 0, endFrame = 0;
  logic checkOut, checkValid, errFlag;
  int nChk = 0, nBad = 0;

  fcs_unit u0 (.clk(clk), .rst(rst), .modeSel(modeSel), .polySel(polySel),
    .clearFrame(clearFrame), .bitValid(bitValid), .bitIn(bitIn),
    .shiftOut(shiftOut), .endFrame(endFrame), .checkOut(checkOut),
    .checkValid(checkValid), .errFlag(errFlag));

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [15:0] mstep(logic [15:0] c, logic b, logic [15:0] p);
    return (c[15] ^ b) ? ({c[14:0], 1'b0} ^ p) : {c[14:0], 1'b0};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulseClear();
    @(negedge clk); clearFrame = 1;
    @(negedge clk); clearFrame = 0;
  endtask

  task automatic feedBit(logic b);
    @(negedge clk); bitValid = 1; bitIn = b;
    @(negedge clk); bitValid = 0;
  endtask

  // draw 16 check bits, checking checkValid each time
  task automatic drawCheck(string req, logic expValid, output logic [15:0] got);
    got = '0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); shiftOut = 1; #1;
      got = {got[14:0], checkOut};
      if (i == 0) check({req, " valid"}, checkValid, expValid);
    end
    @(negedge clk); shiftOut = 0;
  endtask

  task automatic pulseEnd();
    @(negedge clk); endFrame = 1;
    @(negedge clk); endFrame = 0;
  endtask

  initial begin
    #(CLK_P * 200000);
    nBad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk + 1, nBad);
    $finish;
  end

  initial begin
    logic [15:0] got, model, poly, pre, inv;
    logic [7:0] msg [4];
    repeat (3) @(negedge clk);
    // R9: reset preset in bit-oriented mode -> inverted ones = 0
    rst = 0;
    #1 check("R9 err after reset", errFlag, 0);
    drawCheck("R9 bit", 1'b1, got);
    check("R9 bit-mode reset preset", got, 16'h0000);
    @(negedge clk); rst = 1; modeSel = 2'b10; @(negedge clk); rst = 0;
    drawCheck("R9 byte", 1'b1, got);
    check("R9 byte-mode reset preset", got, 16'h0000);

    // sweep: cfg 0 = bit-oriented, 1 = byte CRC-16, 2 = byte CCITT
    for (int cfg = 0; cfg < 3; cfg++) begin
      modeSel = (cfg == 0) ? 2'b01 : 2'b10;
      polySel = (cfg == 2);
      poly = (cfg == 1) ? 16'h8005 : 16'h1021;
      pre  = (cfg == 0) ? 16'hFFFF : 16'h0000;
      inv  = pre;
      for (int len = 0; len < 5; len++) begin
        for (int k = 0; k < 4; k++) msg[k] = 8'(8'h35 * (k + 1) + len * 17 + cfg * 5);
        // transmit
        pulseClear();
        model = pre;
        for (int k = 0; k < len; k++)
          for (int b = 0; b < 8; b++) begin
            feedBit(msg[k][b]);
            model = mstep(model, msg[k][b], poly);
          end
        drawCheck(cfg == 0 ? "R2" : "R4", 1'b1, got);
        check(cfg == 0 ? "R1 R2 bit-mode check field" : "R3 R4 byte-mode check field",
              got, model ^ inv);
        // receive intact, then corrupted (one data or check bit flipped)
        for (int bad = 0; bad < 2; bad++) begin
          pulseClear();
          for (int k = 0; k < len; k++)
            for (int b = 0; b < 8; b++)
              feedBit(msg[k][b] ^ (bad == 1 && k == len - 1 && b == 3));
          for (int i = 15; i >= 0; i--)
            feedBit(got[i] ^ (bad == 1 && len == 0 && i == 5));
          pulseEnd();
          check(cfg == 0 ? "R7 bit-mode verdict" : "R8 byte-mode verdict",
                errFlag, 32'(bad));
        end
        // R8: verdict holds, clear drops it
        @(negedge clk);
        check("R8 verdict held", errFlag, 1);
        pulseClear();
        check("R8 clear drops verdict", errFlag, 0);
      end
    end

    // R6: bits without bitValid ignored
    modeSel = 2'b10; polySel = 0;
    pulseClear();
    @(negedge clk); bitIn = 1; @(negedge clk); @(negedge clk); bitIn = 0;
    feedBit(1);
    drawCheck("R6", 1'b1, got);
    check("R6 only strobed bits fold", got, mstep(16'h0, 1'b1, 16'h8005));

    // R5: no-error-control mode leaves register and verdict untouched
    for (int m = 0; m < 4; m += 3) begin
      modeSel = 2'b01; pulseClear();
      modeSel = 2'(m);
      for (int i = 0; i < 5; i++) feedBit(1'(i));
      drawCheck("R5 none", 1'b0, got);
      pulseEnd();
      check("R5 no verdict in none mode", errFlag, 0);
      modeSel = 2'b01;
      drawCheck("R5", 1'b1, got);
      check("R5 register untouched", got, 16'h0000);
    end

    // R10: clear with bitValid and endFrame in the same cycle
    modeSel = 2'b01;
    pulseClear();
    feedBit(1); pulseEnd();
    check("R10 setup verdict", errFlag, 1);
    @(negedge clk); clearFrame = 1; bitValid = 1; bitIn = 1; endFrame = 1;
    @(negedge clk); clearFrame = 0; bitValid = 0; endFrame = 0;
    check("R10 clear beats endFrame", errFlag, 0);
    drawCheck("R10", 1'b1, got);
    check("R10 clear beats bitValid", got, 16'h0000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule